// File: doc/BRIEF.md
# Calendar Tick Increment Engine

This block holds the time-of-day and calendar of a real-time clock and moves it forward by one second each time a one-second tick arrives. Seconds, minutes, hours, weekday, date, month and year carry into each other. The month lengths include a leap February. Two daylight-saving jumps are available as an option. All bytes are kept either as plain binary or as packed BCD. Hours are shown in 24-hour form or in 12-hour form, where bit 7 of the hour byte marks the afternoon. After each step the new time is compared with three alarm bytes. An alarm byte with its top two bits set matches any value.

Software reaches the ten bytes through a simple byte-wide register port. The engine keeps two copies of the time: a working copy that always counts, and a copy that software sees. While the hold control is high, the copy that software sees is frozen and takes writes. The working copy keeps counting. When hold drops, the bytes written during the hold replace the working values. The merged time is then published, together with any tick that lands in the same cycle.

Top module: `cal_tick_engine`

## Requirements
- R1: After reset the ten bytes read: address 0 seconds 00, address 1 minutes 00, address 2 hours 00, address 3 weekday 01, address 4 date 01, address 5 month 01, address 6 year 00, and the alarm bytes at address 7 (seconds), 8 (minutes) and 9 (hours) 00. `alarm_hit` and `upd_done` are low.
- R2: A write with `we` high stores `wdata` at `addr`, and `rdata` shows the byte at `addr` in the same cycle. Bit 7 of the seconds byte is always stored and read as 0. Addresses 10 to 15 read as 00. With hold low, a write to a time byte also sets the working copy.
- R3: Each tick adds one second. Seconds and minutes wrap from 59 to 0 and carry. In 24-hour mode (`hr24`=1) the hours wrap from 23 to 0 and advance the day. `bin_mode`=1 selects binary bytes and `bin_mode`=0 selects BCD bytes, so for example 0x59 in BCD is 0x3B in binary.
- R4: In 12-hour mode (`hr24`=0) the hour byte holds 1 to 12, with bit 7 = 1 for PM. 11:59:59 AM is followed by 12:00:00 PM (BCD 0x92, binary 0x8C). 12:59:59 PM is followed by 1 PM (0x81). 11:59:59 PM is followed by 12 AM (BCD 0x12), and the date advances.
- R5: At a day change the weekday goes from 7 to 1 and otherwise adds 1. The date wraps to 1 after the last day of the month: 30 days for April, June, September and November, 31 days for the other months except February. The month wraps from 12 to 1 and advances the year. The year wraps from 99 to 0.
- R6: February has 29 days when the year is divisible by 4, and 28 days otherwise.
- R7: With `dst_en`=1, on a Sunday (weekday 1) in April with date 1 to 7, the time 01:59:59 is followed by 03:00:00. With `dst_en`=0, or on another Sunday of April, 02:00:00 follows as usual.
- R8: With `dst_en`=1, on a Sunday in October with date 25 to 31, the first pass through 01:59:59 is followed by 01:00:00. The second pass on the same day goes on to 02:00:00.
- R9: On each tick, `alarm_hit` pulses when each of the alarm bytes for hour, minute and second either equals the new time byte or has bits 7:6 = 11.
- R10: While `set_hold`=1 the user-visible time bytes do not change except by writes, and ticks still advance the working copy. In the first cycle after `set_hold` falls, the time bytes written during the hold replace the working values, and the merged time becomes visible.
- R11: `upd_done` is high for exactly the one clock after the edge that took a tick, and this happens whether or not hold is set. `alarm_hit` is only ever high in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-second tick, one clock wide |
| bin_mode | input | 1 | 1 = binary bytes, 0 = BCD bytes |
| hr24 | input | 1 | 1 = 24-hour format, 0 = 12-hour format |
| dst_en | input | 1 | Enables the daylight-saving jumps |
| set_hold | input | 1 | Freezes the user-visible copy |
| we | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data |
| alarm_hit | output | 1 | Alarm match pulse |
| upd_done | output | 1 | Update finished pulse |

## Verification
The bench drives the carry chain through its own wrap points: end of year, a 30-day month, and February in leap and common years, in both encodings. A decoder that confused the encodings would yield bytes such as 0x5A in place of 0x00. The 12-hour checks cover the noon and midnight crossings, where an off-by-twelve error would show 0x80 or 0x00 instead of 0x92 or 0x12. The daylight-saving tests repeat the October hour: an engine without its once-per-day guard would fall back from 01:59:59 to 01:00:00 forever. The hold test checks that the visible seconds stay frozen while the working copy counts on, and that a minute written during the hold survives the release.

// File: rtl/cal_tick_engine.sv
module cal_tick_engine #(
  parameter int NB = 10,
  parameter int NT = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       bin_mode,
  input  logic       hr24,
  input  logic       dst_en,
  input  logic       set_hold,
  input  logic       we,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       alarm_hit,
  output logic       upd_done
);
  logic [7:0] ub [NB];
  logic [7:0] kb [NT];
  logic [7:0] base [NT];
  logic [7:0] nxt [NT];
  logic [NT-1:0] dirty;
  logic resync, fb_done, load;
  logic [6:0] s, m, h, dw, dt, mo, yr, hv, dim;
  logic [6:0] ns, nm, nh, ndw, ndt, nmo, nyr, h12;
  logic dayc, fall, spring, fall_ok, match;

  function automatic logic [6:0] dec(input logic [7:0] b, input logic bin);
    return bin ? b[6:0] : 7'(b[7:4] * 4'd10 + {3'd0, b[3:0]});
  endfunction

  function automatic logic [7:0] enc(input logic [6:0] v, input logic bin);
    logic [6:0] t, o;
    t = v / 7'd10;
    o = v % 7'd10;
    return bin ? {1'b0, v} : {t[3:0], o[3:0]};
  endfunction

  function automatic logic amatch(input logic [7:0] a, input logic [7:0] t);
    return (a[7:6] == 2'b11) || (a == t);
  endfunction

  assign load = resync && !set_hold;

  always_comb
    for (int i = 0; i < NT; i++)
      base[i] = (load && dirty[i]) ? ub[i] : kb[i];

  always_comb begin
    s  = dec({1'b0, base[0][6:0]}, bin_mode);
    m  = dec(base[1], bin_mode);
    hv = dec({1'b0, base[2][6:0]}, bin_mode);
    h  = hr24 ? dec(base[2], bin_mode) : 7'((hv == 7'd12 ? 7'd0 : hv) + (base[2][7] ? 7'd12 : 7'd0));
    dw = dec(base[3], bin_mode);
    dt = dec(base[4], bin_mode);
    mo = dec(base[5], bin_mode);
    yr = dec(base[6], bin_mode);
    if (mo == 7'd2) dim = (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
    else if (mo == 7'd4 || mo == 7'd6 || mo == 7'd9 || mo == 7'd11) dim = 7'd30;
    else dim = 7'd31;
  end

  assign spring  = dst_en && dw == 7'd1 && mo == 7'd4 && dt <= 7'd7 && h == 7'd1;
  assign fall_ok = dst_en && !fb_done && dw == 7'd1 && mo == 7'd10 && dt >= 7'd25 && h == 7'd1;

  always_comb begin
    ns = s + 7'd1; nm = m; nh = h; ndw = dw; ndt = dt; nmo = mo; nyr = yr;
    dayc = 1'b0; fall = 1'b0;
    if (s >= 7'd59) begin
      ns = 7'd0; nm = m + 7'd1;
      if (m >= 7'd59) begin
        nm = 7'd0;
        if (spring) nh = 7'd3;
        else if (fall_ok) begin nh = 7'd1; fall = 1'b1; end
        else if (h >= 7'd23) begin nh = 7'd0; dayc = 1'b1; end
        else nh = h + 7'd1;
      end
    end
    if (dayc) begin
      ndw = (dw >= 7'd7) ? 7'd1 : dw + 7'd1;
      if (dt >= dim) begin
        ndt = 7'd1;
        if (mo >= 7'd12) begin
          nmo = 7'd1;
          nyr = (yr >= 7'd99) ? 7'd0 : yr + 7'd1;
        end else nmo = mo + 7'd1;
      end else ndt = dt + 7'd1;
    end
  end

  assign h12 = (nh == 7'd0) ? 7'd12 : (nh > 7'd12 ? nh - 7'd12 : nh);

  always_comb begin
    nxt[0] = enc(ns, bin_mode);
    nxt[1] = enc(nm, bin_mode);
    nxt[2] = hr24 ? enc(nh, bin_mode) : {nh >= 7'd12, enc(h12, bin_mode)[6:0]};
    nxt[3] = enc(ndw, bin_mode);
    nxt[4] = enc(ndt, bin_mode);
    nxt[5] = enc(nmo, bin_mode);
    nxt[6] = enc(nyr, bin_mode);
  end

  assign match = amatch(ub[7], nxt[0]) && amatch(ub[8], nxt[1]) && amatch(ub[9], nxt[2]);

  always_comb begin
    rdata = 8'h00;
    for (int i = 0; i < NB; i++)
      if (addr == 4'(i)) rdata = ub[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) ub[i] <= (i >= 3 && i <= 5) ? 8'h01 : 8'h00;
      for (int i = 0; i < NT; i++) kb[i] <= (i >= 3 && i <= 5) ? 8'h01 : 8'h00;
      dirty <= '0; resync <= 1'b0; fb_done <= 1'b0;
      alarm_hit <= 1'b0; upd_done <= 1'b0;
    end else begin
      upd_done  <= tick;
      alarm_hit <= tick && match;
      resync    <= set_hold;
      if (tick && fall) fb_done <= 1'b1;
      else if (tick && dayc) fb_done <= 1'b0;
      if (load) dirty <= '0;
      for (int i = 0; i < NT; i++) begin
        if (tick || load) kb[i] <= tick ? nxt[i] : base[i];
        if (!set_hold && (tick || load)) ub[i] <= tick ? nxt[i] : base[i];
        if (we && addr == 4'(i)) begin
          if (set_hold) dirty[i] <= 1'b1;
          else kb[i] <= (i == 0) ? {1'b0, wdata[6:0]} : wdata;
        end
      end
      for (int i = 0; i < NB; i++)
        if (we && addr == 4'(i)) ub[i] <= (i == 0) ? {1'b0, wdata[6:0]} : wdata;
    end
  end

  logic [8*NT-1:0] uview;
  always_comb
    for (int i = 0; i < NT; i++) uview[8*i +: 8] = ub[i];

  a_r11_alarm_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |-> upd_done);
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |=> !upd_done);
  a_r2_sec_msb_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 4'd0) |-> !rdata[7]);
  a_r10_user_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(set_hold) && !$past(we)) |-> $stable(uview));
endmodule

// File: tb/cal_tick_engine_test.sv
module cal_tick_engine_test;
  localparam int CLK_NS = 10;
  logic clk = 0, rst_n = 0, tick = 0, bin_mode = 0, hr24 = 1, dst_en = 0, set_hold = 0, we = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic alarm_hit, upd_done;
  int nchk = 0, nbad = 0;
  logic got_done, got_alarm;

  cal_tick_engine uut (.clk(clk), .rst_n(rst_n), .tick(tick), .bin_mode(bin_mode), .hr24(hr24),
    .dst_en(dst_en), .set_hold(set_hold), .we(we), .addr(addr), .wdata(wdata), .rdata(rdata),
    .alarm_hit(alarm_hit), .upd_done(upd_done));

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nchk++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    addr = 4'(a); wdata = d; we = 1;
    @(posedge clk); @(negedge clk);
    we = 0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    addr = 4'(a); #1; d = rdata;
  endtask

  task automatic rchk(input string tag, input int a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic do_tick();
    tick = 1;
    @(posedge clk); @(negedge clk);
    tick = 0;
    got_done = upd_done; got_alarm = alarm_hit;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic set_time(input logic [7:0] sc, mn, hr, dw, dt, mo, yr);
    wr(0, sc); wr(1, mn); wr(2, hr); wr(3, dw); wr(4, dt); wr(5, mo); wr(6, yr);
  endtask

  task automatic t_reset();
    rchk("R1 sec", 0, 8'h00); rchk("R1 min", 1, 8'h00); rchk("R1 hour", 2, 8'h00);
    rchk("R1 dow", 3, 8'h01); rchk("R1 date", 4, 8'h01); rchk("R1 month", 5, 8'h01);
    rchk("R1 year", 6, 8'h00); rchk("R1 alarm sec", 7, 8'h00);
    rchk("R1 alarm min", 8, 8'h00); rchk("R1 alarm hour", 9, 8'h00);
    chk("R1 alarm_hit", {7'd0, alarm_hit}, 8'h00);
    chk("R1 upd_done", {7'd0, upd_done}, 8'h00);
  endtask

  task automatic t_port();
    wr(0, 8'hFF); rchk("R2 sec msb read-only", 0, 8'h7F);
    wr(8, 8'hA5); rchk("R2 alarm min rw", 8, 8'hA5);
    rchk("R2 unused addr", 12, 8'h00);
    wr(8, 8'h00);
  endtask

  task automatic t_bcd();
    bin_mode = 0; hr24 = 1;
    set_time(8'h59, 8'h59, 8'h09, 8'h02, 8'h10, 8'h03, 8'h21);
    do_tick();
    chk("R11 done after tick", {7'd0, got_done}, 8'h01);
    chk("R11 done one cycle", {7'd0, upd_done}, 8'h00);
    rchk("R3 bcd sec", 0, 8'h00); rchk("R3 bcd min", 1, 8'h00); rchk("R3 bcd hour", 2, 8'h10);
    set_time(8'h58, 8'h10, 8'h10, 8'h02, 8'h10, 8'h03, 8'h21);
    do_tick(); rchk("R3 bcd sec step", 0, 8'h59);
  endtask

  task automatic t_bin();
    bin_mode = 1; hr24 = 1;
    set_time(8'h3B, 8'h3B, 8'h17, 8'h07, 8'h1F, 8'h0C, 8'h63);
    do_tick();
    rchk("R3 bin sec", 0, 8'h00); rchk("R3 bin min", 1, 8'h00); rchk("R3 bin hour", 2, 8'h00);
    rchk("R5 dow wrap", 3, 8'h01); rchk("R5 date wrap", 4, 8'h01);
    rchk("R5 month wrap", 5, 8'h01); rchk("R5 year wrap", 6, 8'h00);
  endtask

  task automatic t_12h();
    bin_mode = 0; hr24 = 0;
    set_time(8'h59, 8'h59, 8'h11, 8'h03, 8'h05, 8'h06, 8'h22);
    do_tick(); rchk("R4 noon bcd", 2, 8'h92);
    set_time(8'h59, 8'h59, 8'h92, 8'h03, 8'h05, 8'h06, 8'h22);
    do_tick(); rchk("R4 1pm", 2, 8'h81);
    set_time(8'h59, 8'h59, 8'h91, 8'h03, 8'h05, 8'h06, 8'h22);
    do_tick(); rchk("R4 midnight", 2, 8'h12); rchk("R4 date after midnight", 4, 8'h06);
    bin_mode = 1;
    set_time(8'h3B, 8'h3B, 8'h0B, 8'h03, 8'h05, 8'h06, 8'h16);
    do_tick(); rchk("R4 noon bin", 2, 8'h8C);
    hr24 = 1; bin_mode = 0;
  endtask

  task automatic t_month();
    set_time(8'h59, 8'h59, 8'h23, 8'h04, 8'h30, 8'h04, 8'h21);
    do_tick(); rchk("R5 april end date", 4, 8'h01); rchk("R5 april end month", 5, 8'h05);
    rchk("R5 dow step", 3, 8'h05);
    set_time(8'h59, 8'h59, 8'h23, 8'h04, 8'h30, 8'h01, 8'h21);
    do_tick(); rchk("R5 jan 31 exists", 4, 8'h31);
  endtask

  task automatic t_leap();
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24);
    do_tick(); rchk("R6 leap feb29", 4, 8'h29); rchk("R6 leap month", 5, 8'h02);
    do_tick(); rchk("R6 leap sec step", 0, 8'h01);
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h29, 8'h02, 8'h24);
    do_tick(); rchk("R6 leap to mar date", 4, 8'h01); rchk("R6 leap to mar", 5, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23);
    do_tick(); rchk("R6 common date", 4, 8'h01); rchk("R6 common month", 5, 8'h03);
  endtask

  task automatic t_spring();
    dst_en = 1;
    set_time(8'h59, 8'h59, 8'h01, 8'h01, 8'h02, 8'h04, 8'h23);
    do_tick(); rchk("R7 spring hour", 2, 8'h03); rchk("R7 spring min", 1, 8'h00);
    set_time(8'h59, 8'h59, 8'h01, 8'h01, 8'h09, 8'h04, 8'h23);
    do_tick(); rchk("R7 second sunday", 2, 8'h02);
    dst_en = 0;
    set_time(8'h59, 8'h59, 8'h01, 8'h01, 8'h02, 8'h04, 8'h23);
    do_tick(); rchk("R7 disabled", 2, 8'h02);
  endtask

  task automatic t_fall();
    dst_en = 1;
    set_time(8'h59, 8'h59, 8'h01, 8'h01, 8'h27, 8'h10, 8'h23);
    do_tick(); rchk("R8 fall hour", 2, 8'h01); rchk("R8 fall min", 1, 8'h00);
    wr(0, 8'h59); wr(1, 8'h59);
    do_tick(); rchk("R8 second pass", 2, 8'h02);
    dst_en = 0;
  endtask

  task automatic t_alarm();
    wr(7, 8'h05); wr(8, 8'h10); wr(9, 8'h08);
    set_time(8'h04, 8'h10, 8'h08, 8'h02, 8'h03, 8'h03, 8'h23);
    do_tick(); chk("R9 exact match", {7'd0, got_alarm}, 8'h01);
    set_time(8'h04, 8'h11, 8'h08, 8'h02, 8'h03, 8'h03, 8'h23);
    do_tick(); chk("R9 minute differs", {7'd0, got_alarm}, 8'h00);
    wr(8, 8'hC0); wr(9, 8'hFF);
    set_time(8'h04, 8'h37, 8'h15, 8'h02, 8'h03, 8'h03, 8'h23);
    do_tick(); chk("R9 dont care", {7'd0, got_alarm}, 8'h01);
    chk("R11 alarm with done", {7'd0, got_done}, 8'h01);
    do_tick(); chk("R9 sec differs", {7'd0, got_alarm}, 8'h00);
    wr(7, 8'h00); wr(8, 8'h00); wr(9, 8'h00);
  endtask

  task automatic t_set();
    set_time(8'h30, 8'h20, 8'h10, 8'h02, 8'h03, 8'h03, 8'h23);
    set_hold = 1;
    do_tick(); chk("R11 done during hold", {7'd0, got_done}, 8'h01);
    do_tick(); do_tick();
    rchk("R10 sec frozen", 0, 8'h30);
    wr(1, 8'h45);
    rchk("R10 write in hold", 1, 8'h45);
    set_hold = 0;
    @(posedge clk); @(negedge clk);
    rchk("R10 sec kept counting", 0, 8'h33);
    rchk("R10 written min kept", 1, 8'h45);
    rchk("R10 hour", 2, 8'h10);
    do_tick(); rchk("R10 counts after release", 0, 8'h34);
  endtask

  initial begin
    #(CLK_NS * 100000);
    nbad++; nchk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_port();
    t_bcd();
    t_bin();
    t_12h();
    t_month();
    t_leap();
    t_spring();
    t_fall();
    t_alarm();
    t_set();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule